// File: doc/BRIEF.md
# Dual-Channel Input Capture with Edge Select

This block timestamps transitions on two external input lines. Each channel has its own pin, which passes through a two-stage synchroniser. When a transition of the kind programmed for that channel arrives, the channel stores the current value of one of three 16-bit free-running counters in its capture register. A per-channel selector picks the counter. At the same time the channel raises a sticky detect flag and records whether the transition was rising or falling. The counters are produced elsewhere and enter the block as plain inputs.

Software controls the block through a small register file with combinational reads and single-cycle writes. A 2-bit mode field per channel does two jobs at once: it turns the channel off, or it chooses rising, falling or both edges. A per-channel interrupt enable gates the detect flag onto an interrupt line. A flag is cleared by writing 0 to its bit. A read that is marked as the first half of a read-modify-write returns 1 in every flag position. The write-back then cannot clear a capture that arrived between the read and the write.

Top module: `icap_dual`

## Requirements
- R1: With mode 00 a channel ignores its pin. Its capture register, detect flag and edge indicator keep their values whatever the pin does.
- R2: Mode 01 captures on a rising edge of the pin only. A falling edge changes nothing.
- R3: Mode 10 captures on a falling edge of the pin only. A rising edge changes nothing.
- R4: Mode 11 captures on both rising and falling edges.
- R5: A pin change sampled at clock edge k shows up after clock edge k+2. At that point the capture register holds the selected counter value present just before edge k+2, and the detect flag is 1. The capture registers (addresses 3 and 4) are read-only, so writes to them are ignored. Every valid edge overwrites them.
- R6: Writing 0 to a detect-flag bit clears it, and writing 1 leaves it unchanged. If a capture and a clearing write fall in the same clock cycle, the flag ends at 1.
- R7: A read of the control register with the read-modify-write input high returns 1 in both flag bits. A plain read returns the true flag values.
- R8: The interrupt output of a channel is 1 exactly when its detect flag and its interrupt enable are both 1.
- R9: The edge indicator (address 2, bit n for channel n) is 1 after a capture on a rising edge and 0 after a capture on a falling edge. It resets to 0.
- R10: The selector (address 1, bits [3:0] for channel 0 and [7:4] for channel 1) picks counter 0, 1 or 2 with the codes 0, 1 and 2. Any other code picks counter 0.
- R11: The control register sits at address 0. Bits [1:0] and [3:2] are the modes of channels 0 and 1. Bits 4 and 5 are their interrupt enables, and bits 6 and 7 are their detect flags. After reset every register, including the capture registers, reads 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 2 | Asynchronous capture inputs, bit n for channel n |
| cnt_i | input | 48 | Three 16-bit counter values, counter b at bits [16b+15:16b] |
| reg_addr_i | input | 3 | Register address for reads and writes |
| reg_wr_i | input | 1 | Write strobe, applied at the next clock edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rmw_i | input | 1 | Marks the current read as part of a read-modify-write |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| irq_o | output | 2 | Interrupt request per channel |

## Verification
A detect flag can be set by a capture and cleared by a software write in the same clock cycle. To provoke this, the bench changes a pin and then waits exactly two cycles. It then places a control write with the flag bit at 0 so that the write lands on the clock edge where the capture takes effect. The flag must read 1 afterwards, and the capture register must hold the counter value. A separate case shows that the same write, issued with no capture pending, does clear the flag.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_SEL      = 1;
    localparam int ADDR_EDGE     = 2;
    localparam int ADDR_CAP_BASE = 3;

endpackage

// File: rtl/icap_sync.sv
module icap_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic meta;
        logic stable;
        logic last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = pin_i;
        sync_d.stable = sync_q.meta;
        sync_d.last   = sync_q.stable;
        rise_o        = sync_q.stable & ~sync_q.last;
        fall_o        = ~sync_q.stable & sync_q.last;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    // R4
    edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o}));

    // R2
    rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/icap_chan.sv
module icap_chan #(
    parameter int CNT_W = 16,
    parameter int NBASE = 3,
    parameter int SEL_W = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [1:0]             mode_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [NBASE*CNT_W-1:0] cnt_i,
    input  logic                   rise_i,
    input  logic                   fall_i,
    input  logic                   clr_i,
    output logic [CNT_W-1:0]       cap_o,
    output logic                   flag_o,
    output logic                   edge_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
        logic             edge_rise;
    } chan_t;

    chan_t            st_d, st_q;
    logic [CNT_W-1:0] base;
    logic             hit;

    always_comb begin
        base = cnt_i[CNT_W-1:0];
        for (int b = 1; b < NBASE; b++) begin
            if (sel_i == SEL_W'(b)) base = cnt_i[b*CNT_W +: CNT_W];
        end
        hit  = (rise_i & mode_i[0]) | (fall_i & mode_i[1]);
        st_d = st_q;
        if (hit) begin
            st_d.cap       = base;
            st_d.flag      = 1'b1;
            st_d.edge_rise = rise_i;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;
    assign edge_o = st_q.edge_rise;

    // R1
    off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == icap_pkg::EDGE_OFF) |=> ($stable(cap_o) && $stable(edge_o)));

    // R3
    fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && mode_i == icap_pkg::EDGE_FALL) |=> ($stable(cap_o) && $stable(edge_o)));

    // R5
    flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> ($past(mode_i) != icap_pkg::EDGE_OFF));

    // R6
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !rise_i && !fall_i) |=> !flag_o);

endmodule

// File: rtl/icap_dual.sv
module icap_dual #(
    parameter int NCH   = 2,
    parameter int CNT_W = 16,
    parameter int NBASE = 3,
    parameter int SEL_W = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(icap_pkg::ADDR_CAP_BASE + NCH),
    localparam int WD_W   = (4*NCH > NCH*SEL_W) ? 4*NCH : NCH*SEL_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NCH-1:0]         pin_i,
    input  logic [NBASE*CNT_W-1:0] cnt_i,
    input  logic [ADDR_W-1:0]      reg_addr_i,
    input  logic                   reg_wr_i,
    input  logic [WD_W-1:0]        reg_wdata_i,
    input  logic                   reg_rmw_i,
    output logic [DATA_W-1:0]      reg_rdata_o,
    output logic [NCH-1:0]         irq_o
);

    localparam int IE_LSB   = 2*NCH;
    localparam int FLAG_LSB = 3*NCH;

    typedef struct packed {
        logic [NCH-1:0][1:0]       mode;
        logic [NCH-1:0]            ie;
        logic [NCH-1:0][SEL_W-1:0] sel;
    } cfg_t;

    cfg_t                      cfg_d, cfg_q;
    logic [NCH-1:0]            clr;
    logic [NCH-1:0]            rise, fall;
    logic [NCH-1:0]            flag, edge_ind;
    logic [NCH-1:0][CNT_W-1:0] cap;
    logic                      wr_ctrl, wr_sel;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_W'(icap_pkg::ADDR_CTRL));
    assign wr_sel  = reg_wr_i && (reg_addr_i == ADDR_W'(icap_pkg::ADDR_SEL));

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (wr_ctrl) begin
                cfg_d.mode[i] = reg_wdata_i[2*i +: 2];
                cfg_d.ie[i]   = reg_wdata_i[IE_LSB + i];
                clr[i]        = ~reg_wdata_i[FLAG_LSB + i];
            end
            if (wr_sel) cfg_d.sel[i] = reg_wdata_i[i*SEL_W +: SEL_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        icap_sync u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (pin_i[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );

        icap_chan #(
            .CNT_W (CNT_W),
            .NBASE (NBASE),
            .SEL_W (SEL_W)
        ) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .mode_i (cfg_q.mode[g]),
            .sel_i  (cfg_q.sel[g]),
            .cnt_i  (cnt_i),
            .rise_i (rise[g]),
            .fall_i (fall[g]),
            .clr_i  (clr[g]),
            .cap_o  (cap[g]),
            .flag_o (flag[g]),
            .edge_o (edge_ind[g])
        );

        assign irq_o[g] = flag[g] & cfg_q.ie[g];
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(icap_pkg::ADDR_CTRL)) begin
            for (int i = 0; i < NCH; i++) begin
                reg_rdata_o[2*i +: 2]       = cfg_q.mode[i];
                reg_rdata_o[IE_LSB + i]     = cfg_q.ie[i];
                reg_rdata_o[FLAG_LSB + i]   = flag[i] | reg_rmw_i;
            end
        end else if (reg_addr_i == ADDR_W'(icap_pkg::ADDR_SEL)) begin
            for (int i = 0; i < NCH; i++) reg_rdata_o[i*SEL_W +: SEL_W] = cfg_q.sel[i];
        end else if (reg_addr_i == ADDR_W'(icap_pkg::ADDR_EDGE)) begin
            reg_rdata_o[NCH-1:0] = edge_ind;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr_i == ADDR_W'(icap_pkg::ADDR_CAP_BASE + i))
                    reg_rdata_o[CNT_W-1:0] = cap[i];
            end
        end
    end

    // R7
    rmw_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rmw_i && reg_addr_i == ADDR_W'(icap_pkg::ADDR_CTRL))
            |-> (reg_rdata_o[FLAG_LSB +: NCH] == {NCH{1'b1}}));

    // R8
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.ie == '0) |-> (irq_o == '0));

endmodule

// File: tb/icap_dual_bench.sv
module icap_dual_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin = 2'b00;
    logic [47:0] cnt = '0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rmw = 1'b0;
    logic [15:0] rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    icap_dual u_icap_dual (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pin),
        .cnt_i       (cnt),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr_en),
        .reg_wdata_i (wdata),
        .reg_rmw_i   (rmw),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {mode[1:0], pin_before, pin_after, expect_capture, expect_rising}
    localparam logic [5:0] VEC [8] = '{
        6'b01_01_1_1, 6'b01_10_0_0, 6'b10_01_0_0, 6'b10_10_1_0,
        6'b11_01_1_1, 6'b11_10_1_0, 6'b00_01_0_0, 6'b00_10_0_0
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic m, output logic [15:0] d);
        addr = a; rmw = m;
        #1;
        d = rdata;
        rmw = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] exp_cap;
        logic        exp_edge;
        exp_cap = '0;
        exp_edge = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // R11 reset state, R9 edge reset
        rd(3'd0, 1'b0, d); chk("R11 ctrl reset", d, 16'h0000);
        rd(3'd1, 1'b0, d); chk("R11 sel reset", d, 16'h0000);
        rd(3'd2, 1'b0, d); chk("R9 edge reset", d, 16'h0000);
        rd(3'd3, 1'b0, d); chk("R11 cap0 reset", d, 16'h0000);
        rd(3'd4, 1'b0, d); chk("R11 cap1 reset", d, 16'h0000);
        chk("R11 irq reset", {14'd0, irq}, 16'h0000);

        // R1 R2 R3 R4 R9: vector walk on channel 0
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, 8'h00);
            @(negedge clk); pin[0] = VEC[i][3];
            cycles(4);
            wr(3'd0, {6'b000000, VEC[i][5:4]});
            cnt[15:0] = 16'h1000 + 16'(i);
            @(negedge clk); pin[0] = VEC[i][2];
            cycles(3);
            if (VEC[i][1]) begin
                exp_cap = 16'h1000 + 16'(i);
                exp_edge = VEC[i][0];
            end
            rd(3'd0, 1'b0, d); chk($sformatf("R1-4 vec%0d flag (R2 R3 R4 R1)", i), {15'd0, d[6]}, {15'd0, VEC[i][1]});
            rd(3'd3, 1'b0, d); chk($sformatf("R5 vec%0d capture", i), d, exp_cap);
            rd(3'd2, 1'b0, d); chk($sformatf("R9 vec%0d edge", i), {15'd0, d[0]}, {15'd0, exp_edge});
        end

        // R5 latency on channel 1, mode 01
        wr(3'd0, 8'h04);
        cnt[15:0] = 16'h5A5A;
        @(negedge clk); pin[1] = 1'b1;
        cycles(2);
        rd(3'd0, 1'b0, d); chk("R5 no flag after two edges", {15'd0, d[7]}, 16'h0000);
        @(negedge clk);
        rd(3'd0, 1'b0, d); chk("R5 flag after three edges", {15'd0, d[7]}, 16'h0001);
        rd(3'd4, 1'b0, d); chk("R5 cap1 value", d, 16'h5A5A);
        wr(3'd4, 8'hFF);
        rd(3'd4, 1'b0, d); chk("R5 cap1 write ignored", d, 16'h5A5A);

        // R10 selector on channel 1, mode 11
        cnt = {16'h2222, 16'h1111, 16'h0AAA};
        wr(3'd0, 8'h0C);
        wr(3'd1, 8'h10);
        rd(3'd1, 1'b0, d); chk("R10 sel readback", d, 16'h0010);
        @(negedge clk); pin[1] = 1'b0; cycles(3);
        rd(3'd4, 1'b0, d); chk("R10 code 1 picks counter 1", d, 16'h1111);
        wr(3'd1, 8'h20);
        @(negedge clk); pin[1] = 1'b1; cycles(3);
        rd(3'd4, 1'b0, d); chk("R10 code 2 picks counter 2", d, 16'h2222);
        wr(3'd1, 8'h70);
        @(negedge clk); pin[1] = 1'b0; cycles(3);
        rd(3'd4, 1'b0, d); chk("R10 code 7 picks counter 0", d, 16'h0AAA);

        // R8 interrupt gating (channel 1 flag is set)
        wr(3'd0, 8'hEC);
        chk("R8 irq with enable", {14'd0, irq}, 16'h0002);
        wr(3'd0, 8'hCC);
        chk("R8 irq without enable", {14'd0, irq}, 16'h0000);

        // R6 write 1 keeps, write 0 clears
        rd(3'd0, 1'b0, d); chk("R6 flag1 kept after writing 1", {15'd0, d[7]}, 16'h0001);
        wr(3'd0, 8'h4C);
        rd(3'd0, 1'b0, d); chk("R6 flag1 cleared by 0", {15'd0, d[7]}, 16'h0000);

        // R7 read-modify-write view of flags
        wr(3'd0, 8'h00);
        rd(3'd0, 1'b1, d); chk("R7 rmw read flags", {14'd0, d[7:6]}, 16'h0003);
        rd(3'd0, 1'b0, d); chk("R7 plain read flags", {14'd0, d[7:6]}, 16'h0000);

        // R6 collision: capture and clearing write in the same cycle
        wr(3'd0, 8'h01);
        pin[0] = 1'b0; cycles(4);
        cnt[15:0] = 16'h7E57;
        @(negedge clk); pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h01; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        rd(3'd0, 1'b0, d); chk("R6 capture wins over clear", {15'd0, d[6]}, 16'h0001);
        rd(3'd3, 1'b0, d); chk("R6 capture value in collision", d, 16'h7E57);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule